// File: doc/BRIEF.md
# Duplicated Register File with Parity Repair

This block is a small register file with one write port and two read ports. It holds two full copies of its contents. Each copy has a single read port. Read port A is always served by copy 0 and read port B by copy 1. Every write lands in both copies in the same cycle as a word of the form `{parity, data}`, where the parity bit is the XOR of the data bits. Each stored word therefore has even parity over all DW+1 bits.

Reads are combinational, so the data goes to the consumer in the same cycle with no added latency. The parity check runs in parallel with that use. When an enabled read sees odd parity, the block raises `replay` in that same cycle, so the consumer throws the result away. A small repair controller then copies the word at that address from the other copy into the damaged one. This takes one fetch cycle and one mend cycle, with `busy` high for both. After that the consumer repeats the operation. If the twin word is also damaged, `uncorrectable` pulses and nothing is written.

Controller states and transitions:
- IDLE goes to FETCH on a detected error.
- FETCH goes to MEND when the twin word has good parity.
- FETCH goes back to IDLE when the twin word is also bad.
- MEND always goes back to IDLE.

A bit-flip input models a single-event upset in one stored bit of one copy.

Top module: `rf_dup_parity`

## Requirements
- R1: After reset, every word of both copies is zero with even parity. `busy`, `replay` and `uncorrectable` are low, and every read returns 0.
- R2: A write while not busy stores `{^wr_data, wr_data}` at `wr_addr` in both copies at the same clock edge. The parity bit is bit DW of the stored word. It is visible on both read ports from the next cycle.
- R3: Read data is combinational. `rd_data_a` shows the data bits of copy 0 at `rd_addr_a`, and `rd_data_b` shows the data bits of copy 1 at `rd_addr_b`. Both appear in the cycle the address is presented, even when the word is corrupt.
- R4: In IDLE, an enabled read whose stored word has odd parity raises `replay` in that same cycle. If both ports report an error, port A is repaired first and port B's error is found again on the replayed read.
- R5: After a cycle with `replay`, `busy` is high for the FETCH and MEND cycles and low in the cycle after. The damaged word is then equal to its twin in the other copy.
- R6: If the twin word read in FETCH also has odd parity, `uncorrectable` is high in that FETCH cycle. No write takes place, and `busy` is low from the next cycle.
- R7: While `busy` is high, `wr_en`, `rd_en_a` and `rd_en_b` are ignored. No word is written and no `replay` is raised.
- R8: A cycle with `upset_en` high inverts bit `upset_bit` of the word at `upset_addr` in the copy chosen by `upset_copy`. Copy 0 is selected by 0 and copy 1 by 1. Bits 0 to DW-1 are data and bit DW is parity.
- R9: A corrupt word read with its port's read enable low causes no `replay`. A corrupt word in one copy is not seen by the port served by the other copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en_a | input | 1 | Read enable of port A (parity check on copy 0) |
| rd_addr_a | input | AW | Read address of port A |
| rd_data_a | output | DW | Read data of port A, same cycle |
| rd_en_b | input | 1 | Read enable of port B (parity check on copy 1) |
| rd_addr_b | input | AW | Read address of port B |
| rd_data_b | output | DW | Read data of port B, same cycle |
| upset_en | input | 1 | Flip one stored bit this cycle |
| upset_copy | input | 1 | Copy selected for the flip |
| upset_addr | input | AW | Word selected for the flip |
| upset_bit | input | $clog2(DW+1) | Bit index to flip (DW is the parity bit) |
| replay | output | 1 | Result of this cycle is bad; repeat after busy falls |
| busy | output | 1 | Repair in progress; inputs ignored |
| uncorrectable | output | 1 | Both copies bad at the repair address |

## Verification
The bench corrupts data bits and the parity bit in each copy. It checks that the bad word is forwarded unchanged in the error cycle, that `replay` appears in that cycle, and that the word is restored after exactly two busy cycles. A design with the copies swapped between the ports, or with the repair aimed at the wrong copy, would show a second `replay` on the repeated read. It also drives simultaneous errors on both ports at different addresses, where a design without port A priority or a lost port B error would mend the wrong word first or never mend the second. Two further cases are covered. One is a damaged twin, where a design that writes anyway would spread bad data with no `uncorrectable` pulse. The other is a write issued during `busy`, which a design that fails to stall would commit.

// File: rtl/rf_dup_pkg.sv
package rf_dup_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MEND  = 2'd2
    } rep_state_t;

    localparam int unsigned NUM_COPIES = 2;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW:0]   wword,
    input  logic [AW-1:0] raddr,
    output logic [DW:0]   rword,
    input  logic          flip_en,
    input  logic [AW-1:0] flip_addr,
    input  logic [DW:0]   flip_mask
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW:0] mem [DEPTH];
    logic [DW:0] nxt [DEPTH];

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            nxt[e] = mem[e];
            if (we && waddr == AW'(e)) nxt[e] = wword;
            if (flip_en && flip_addr == AW'(e)) nxt[e] = nxt[e] ^ flip_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= nxt[e];
        end
    end

    assign rword = mem[raddr];

    // R2
    store_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(flip_en && flip_addr == waddr) && ^wword == 1'b0)
        |=> (^mem[$past(waddr)] == 1'b0));
endmodule

// File: rtl/rf_par_chk.sv
module rf_par_chk #(
    parameter int unsigned DW = 8
) (
    input  logic        en,
    input  logic [DW:0] word,
    output logic        err
);
    assign err = en & (^word);
endmodule

// File: rtl/rf_repair_ctl.sv
module rf_repair_ctl
    import rf_dup_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_a,
    input  logic          err_b,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    input  logic [DW:0]   src_word,
    output logic          busy,
    output logic          replay,
    output logic          uncorrectable,
    output logic [AW-1:0] fix_addr,
    output logic          fix_copy,
    output logic          fix_we,
    output logic [DW:0]   fix_word
);
    rep_state_t state, state_nxt;
    logic src_bad;

    assign src_bad = ^src_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fix_addr <= '0;
            fix_copy <= 1'b0;
            fix_word <= '0;
        end else begin
            if (state == ST_IDLE && (err_a || err_b)) begin
                fix_addr <= err_a ? addr_a : addr_b;
                fix_copy <= !err_a;
            end
            if (state == ST_FETCH) fix_word <= src_word;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (err_a || err_b) state_nxt = ST_FETCH;
            ST_FETCH: state_nxt = src_bad ? ST_IDLE : ST_MEND;
            ST_MEND:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy          = 1'b0;
        replay        = 1'b0;
        uncorrectable = 1'b0;
        fix_we        = 1'b0;
        unique case (state)
            ST_IDLE:  replay = err_a | err_b;
            ST_FETCH: begin
                busy          = 1'b1;
                uncorrectable = src_bad;
            end
            ST_MEND:  begin
                busy   = 1'b1;
                fix_we = 1'b1;
            end
            default:  ;
        endcase
    end

    // R5
    replay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay |=> busy);
    // R7
    no_replay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !replay);
    // R6
    unc_after_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |-> ($past(replay) && !fix_we));
    // R5
    mend_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_we |=> !busy);
endmodule

// File: rtl/rf_dup_parity.sv
module rf_dup_parity
    import rf_dup_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     rd_en_a,
    input  logic [AW-1:0]            rd_addr_a,
    output logic [DW-1:0]            rd_data_a,
    input  logic                     rd_en_b,
    input  logic [AW-1:0]            rd_addr_b,
    output logic [DW-1:0]            rd_data_b,
    input  logic                     upset_en,
    input  logic                     upset_copy,
    input  logic [AW-1:0]            upset_addr,
    input  logic [$clog2(DW+1)-1:0]  upset_bit,
    output logic                     replay,
    output logic                     busy,
    output logic                     uncorrectable
);
    logic [DW:0]   word_c  [NUM_COPIES];
    logic [AW-1:0] raddr_c [NUM_COPIES];
    logic [AW-1:0] port_addr [NUM_COPIES];
    logic          port_en [NUM_COPIES];
    logic          err_c   [NUM_COPIES];
    logic          we_c    [NUM_COPIES];
    logic [DW:0]   wword, flip_mask, fix_word;
    logic [AW-1:0] fix_addr;
    logic          fix_copy, fix_we;

    assign port_addr[0] = rd_addr_a;
    assign port_addr[1] = rd_addr_b;
    assign port_en[0]   = rd_en_a;
    assign port_en[1]   = rd_en_b;
    assign wword        = fix_we ? fix_word : {^wr_data, wr_data};
    assign flip_mask    = {{DW{1'b0}}, 1'b1} << upset_bit;

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        assign raddr_c[c] = busy ? fix_addr : port_addr[c];
        assign we_c[c]    = (wr_en & ~busy) | (fix_we & (fix_copy == c[0]));

        rf_store #(.DW(DW), .AW(AW)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (we_c[c]),
            .waddr     (fix_we ? fix_addr : wr_addr),
            .wword     (wword),
            .raddr     (raddr_c[c]),
            .rword     (word_c[c]),
            .flip_en   (upset_en & (upset_copy == c[0])),
            .flip_addr (upset_addr),
            .flip_mask (flip_mask)
        );

        rf_par_chk #(.DW(DW)) u_chk (
            .en   (port_en[c] & ~busy),
            .word (word_c[c]),
            .err  (err_c[c])
        );
    end

    assign rd_data_a = word_c[0][DW-1:0];
    assign rd_data_b = word_c[1][DW-1:0];

    rf_repair_ctl #(.DW(DW), .AW(AW)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_a         (err_c[0]),
        .err_b         (err_c[1]),
        .addr_a        (rd_addr_a),
        .addr_b        (rd_addr_b),
        .src_word      (fix_copy ? word_c[0] : word_c[1]),
        .busy          (busy),
        .replay        (replay),
        .uncorrectable (uncorrectable),
        .fix_addr      (fix_addr),
        .fix_copy      (fix_copy),
        .fix_we        (fix_we),
        .fix_word      (fix_word)
    );
endmodule

// File: tb/tb_rf_dup_parity.sv
`timescale 1ns/100ps
module tb_rf_dup_parity;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, rd_en_a = 0, rd_en_b = 0, upset_en = 0, upset_copy = 0;
    logic [AW-1:0] wr_addr = 0, rd_addr_a = 0, rd_addr_b = 0, upset_addr = 0;
    logic [DW-1:0] wr_data = 0;
    logic [3:0] upset_bit = 0;
    logic [DW-1:0] rd_data_a, rd_data_b;
    logic replay, busy, uncorrectable;

    always #2.5 clk = ~clk;

    rf_dup_parity #(.DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .upset_en(upset_en), .upset_copy(upset_copy), .upset_addr(upset_addr),
        .upset_bit(upset_bit), .replay(replay), .busy(busy), .uncorrectable(uncorrectable)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    string phase = "R1";

    // reference model
    logic [DW:0] m0 [DEPTH];
    logic [DW:0] m1 [DEPTH];
    int st = 0, fa = 0, badc = 0;
    logic [DW:0] hold;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, phase, act, exp);
        end
    endtask

    task automatic cyc(input int we, input int wa, input int wd,
                       input int ea, input int ra, input int eb, input int rb,
                       input int ue = 0, input int uc = 0, input int ua = 0, input int ub = 0);
        logic [DW:0] wA, wB, src, mask;
        int nst;
        @(negedge clk);
        wr_en = we[0]; wr_addr = wa[AW-1:0]; wr_data = wd[DW-1:0];
        rd_en_a = ea[0]; rd_addr_a = ra[AW-1:0];
        rd_en_b = eb[0]; rd_addr_b = rb[AW-1:0];
        upset_en = ue[0]; upset_copy = uc[0]; upset_addr = ua[AW-1:0]; upset_bit = ub[3:0];
        #1;
        wA = m0[ra]; wB = m1[rb]; nst = st;
        chk("R5 busy", busy, st != 0);
        if (st == 0) begin
            logic rep;
            rep = 0;
            if (ea != 0 && ^wA) begin rep = 1; nst = 1; fa = ra; badc = 0; end
            else if (eb != 0 && ^wB) begin rep = 1; nst = 1; fa = rb; badc = 1; end
            chk("R4 replay", replay, rep);
            chk("R6 unc", uncorrectable, 0);
            if (ea != 0) chk("R3 rd_data_a", rd_data_a, wA[DW-1:0]);
            if (eb != 0) chk("R3 rd_data_b", rd_data_b, wB[DW-1:0]);
            if (we != 0) begin
                m0[wa] = {^wd[DW-1:0], wd[DW-1:0]};
                m1[wa] = {^wd[DW-1:0], wd[DW-1:0]};
            end
        end else if (st == 1) begin
            src = badc ? m0[fa] : m1[fa];
            chk("R7 replay", replay, 0);
            chk("R6 unc", uncorrectable, ^src);
            if (^src) nst = 0; else begin hold = src; nst = 2; end
        end else begin
            chk("R7 replay", replay, 0);
            chk("R6 unc", uncorrectable, 0);
            if (badc != 0) m1[fa] = hold; else m0[fa] = hold;
            nst = 0;
        end
        if (ue != 0) begin
            mask = (DW+1)'(1) << ub;
            if (uc != 0) m1[ua] = m1[ua] ^ mask; else m0[ua] = m0[ua] ^ mask;
        end
        st = nst;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m0[i] = '0; m1[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, all words zero
        phase = "R1";
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, i, 1, DEPTH - 1 - i);
        // R2/R3: writes land in both copies
        phase = "R2";
        for (int i = 0; i < DEPTH; i++) cyc(1, i, 8'h11 * i + 3, 1, i, 1, i);
        phase = "R3";
        for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, i, 1, (i + 3) % DEPTH);
        // R8/R4/R5: data bit flip in copy 0, read through port A
        phase = "R8";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 3);
        phase = "R5";
        cyc(0, 0, 0, 1, 2, 0, 0);
        cyc(0, 0, 0, 1, 2, 0, 0);
        cyc(0, 0, 0, 1, 2, 0, 0);
        cyc(0, 0, 0, 1, 2, 1, 2);
        // R8: parity bit flip in copy 1, read through port B
        phase = "R8";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 5, DW);
        cyc(0, 0, 0, 0, 0, 1, 5);
        cyc(0, 0, 0, 0, 0, 1, 5);
        cyc(0, 0, 0, 0, 0, 1, 5);
        cyc(0, 0, 0, 1, 5, 1, 5);
        // R9: corrupt word not enabled / seen by other port only
        phase = "R9";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 6, 0);
        cyc(0, 0, 0, 0, 6, 1, 6);
        cyc(0, 0, 0, 0, 6, 0, 6);
        cyc(0, 0, 0, 1, 6, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 6, 1, 6);
        // R4: errors on both ports at different addresses, A first
        phase = "R4";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 3, 7);
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 1, 1, 1, 3);
        // R7: write and reads during busy are ignored
        phase = "R7";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 4);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(1, 7, 8'hAA, 1, 7, 1, 7);
        cyc(1, 7, 8'h55, 1, 7, 1, 7);
        cyc(0, 0, 0, 1, 7, 1, 7);
        cyc(0, 0, 0, 1, 0, 1, 0);
        // R6: both copies damaged at one address
        phase = "R6";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 4, 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 4, 2);
        cyc(0, 0, 0, 1, 4, 0, 0);
        cyc(0, 0, 0, 1, 4, 0, 0);
        cyc(0, 0, 0, 1, 4, 1, 4);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // R2: rewrite clears both copies' damage
        phase = "R2";
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 4, 8'h3C, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 4, 1, 4);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule